// File: doc/BRIEF.md
# Completion Error Header Logging Sequencer

This block raises completion errors for application logic that sits beside a transaction layer. A caller offers one error at a time: a six-bit error class, a function number, a 128-bit packet header and a flag asking for the header to be logged. When logging applies, the block first copies the header into four error-descriptor registers through a small management write port, one 32-bit dword per write, and only then drives the seven-bit error vector and the function number for a single cycle. Without logging it drives the vector in the cycle after acceptance.

A separate saturating counter tracks outstanding master requests, rising on each issue and falling on each completion. The completion-pending output is high whenever that count is above zero.

Top module: `cerr_log_seq`

## Requirements
- R1: After reset, req_ready is 1, and err_vec, err_func, mgmt_wr_en and cpl_pending are all 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1; req_ready is 0 from that edge until the edge that ends the vector pulse, and a request offered while req_ready is 0 has no effect on any output.
- R3: A logging sequence (req_log set and at least one of class bits 2, 3, 4, 5 set) makes exactly four writes in this order: address 0x81C with header[127:96], 0x820 with header[95:64], 0x824 with header[63:32], 0x828 with header[31:0]. The first write strobe appears in the cycle after acceptance.
- R4: A write keeps mgmt_wr_en high and mgmt_addr and mgmt_wdata unchanged until an edge with mgmt_ack high; the next write is presented in the following cycle. mgmt_ack while mgmt_wr_en is 0 is ignored.
- R5: In the cycle after the edge where the last write is acknowledged, err_vec equals {1, class[5:0]} and err_func equals the captured function number; bit 6 of err_vec is never 1 unless one of bits 2 to 5 is also 1.
- R6: If req_log is set but class bits 2 to 5 are all 0, no write is made and err_vec equals {0, class} in the cycle after acceptance.
- R7: If req_log is clear, no write is made and err_vec equals {0, class} with err_func set in the cycle after acceptance.
- R8: err_vec and err_func are nonzero for at most one cycle per accepted request and are 0 in every other cycle.
- R9: The outstanding count rises by one on mreq_issue, falls by one on mreq_done, is unchanged when both or neither are high, and saturates at 2^PEND_W-1 and at 0; cpl_pending is 1 exactly when the count, updated at the previous edge, is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Error request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_class | input | 6 | Error class bits, become err_vec[5:0] |
| req_func | input | 3 | Function number raising the error |
| req_hdr | input | 128 | Packet header to log |
| req_log | input | 1 | Header logging requested |
| mgmt_wr_en | output | 1 | Management write strobe, held until acknowledged |
| mgmt_addr | output | 12 | Management write address |
| mgmt_wdata | output | 32 | Management write data |
| mgmt_ack | input | 1 | Management write acknowledge |
| err_vec | output | 7 | Error vector, bit 6 is the log qualifier |
| err_func | output | 3 | Function number beside the error vector |
| mreq_issue | input | 1 | A master request was issued |
| mreq_done | input | 1 | A completion for a master request arrived |
| cpl_pending | output | 1 | At least one master request is outstanding |

## Verification
The bench builds the block with PEND_W set to 3, so the counter ceiling of 7 is reached after a handful of issue pulses and both saturation limits can be shown through cpl_pending within a short run. All other parameters keep their defaults, which fixes the four-dword header, the 0x81C base and the step of four that the write-order checks rely on. Acknowledge delays from zero to two cycles and stray requests during busy periods bring the hold-until-acknowledged and ignore-while-busy rules within reach.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

    localparam int CLASS_W = 6;
    localparam int VEC_W   = CLASS_W + 1;
    localparam int LOG_BIT = CLASS_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FIRE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CLASS_W-1:0] cls;
        logic               log_en;
    } err_req_t;

    // Header logging is only legal alongside one of class bits 2..5.
    function automatic logic log_allowed(input logic [CLASS_W-1:0] cls);
        return |cls[5:2];
    endfunction

    function automatic logic [VEC_W-1:0] build_vec(input err_req_t r);
        return {r.log_en & log_allowed(r.cls), r.cls};
    endfunction

endpackage

// File: rtl/cerr_hdr_writer.sv
module cerr_hdr_writer #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NWR       = 4,
    parameter int BASE_ADDR = 'h81C,
    parameter int ADDR_STEP = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NWR*DATA_W-1:0] hdr_in,
    input  logic                  ack,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data,
    output logic                  done
);
    localparam int HDR_W = NWR * DATA_W;
    localparam int IDX_W = (NWR > 1) ? $clog2(NWR) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWR - 1);

    logic                 busy_q;
    logic [IDX_W-1:0]     idx_q;
    logic [HDR_W-1:0]     hdr_q;
    logic [DATA_W-1:0]    dword [NWR];

    // Most significant dword goes out first.
    for (genvar g = 0; g < NWR; g++) begin : g_dword
        assign dword[g] = hdr_q[HDR_W-1-g*DATA_W -: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            hdr_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                hdr_q  <= hdr_in;
            end
        end else if (ack) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign wr_en = busy_q;
    assign addr  = ADDR_W'(BASE_ADDR + int'(idx_q) * ADDR_STEP);
    assign data  = dword[idx_q];
    assign done  = busy_q & ack & (idx_q == LAST_IDX);

    // R4: an unacknowledged write holds its strobe, address and data.
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ack) |=> (wr_en && $stable(addr) && $stable(data)));

    // R3: after a non-final acknowledge the next address is one step higher.
    assert_addr_ascend_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ack && !done) |=> (wr_en && addr == $past(addr) + ADDR_W'(ADDR_STEP)));

    // R3: the final acknowledge ends the write phase.
    assert_last_ends_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_en);

endmodule

// File: rtl/cerr_pend_counter.sv
module cerr_pend_counter #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic retire,
    output logic pending
);
    localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (issue && !retire && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (retire && !issue && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pending = (cnt_q != '0);

    // R9: an issue below the ceiling raises the count by one.
    assert_cnt_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (issue && !retire && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9: the count never wraps at either limit.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !retire) |=> cnt_q == CNT_MAX);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !issue) |=> cnt_q == '0);

endmodule

// File: rtl/cerr_seq_ctrl.sv
module cerr_seq_ctrl
    import cerr_pkg::*;
#(
    parameter int FUNC_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CLASS_W-1:0] req_class,
    input  logic [FUNC_W-1:0]  req_func,
    input  logic               req_log,
    output logic               wr_start,
    input  logic               wr_done,
    output logic [VEC_W-1:0]   err_vec,
    output logic [FUNC_W-1:0]  err_func
);
    seq_state_e           state_q;
    err_req_t             req_q;
    logic [FUNC_W-1:0]    func_q;
    logic                 accept;
    logic                 do_log;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid & req_ready;
    assign do_log    = req_log & log_allowed(req_class);
    assign wr_start  = accept & do_log;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            func_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    req_q.cls    <= req_class;
                    req_q.log_en <= req_log;
                    func_q       <= req_func;
                    state_q      <= do_log ? ST_WRITE : ST_FIRE;
                end
                ST_WRITE: if (wr_done) state_q <= ST_FIRE;
                ST_FIRE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign err_vec  = (state_q == ST_FIRE) ? build_vec(req_q) : '0;
    assign err_func = (state_q == ST_FIRE) ? func_q : '0;

    // R5: the log qualifier only rides with one of class bits 2..5.
    assert_log_qual_R5: assert property (@(posedge clk) disable iff (rst)
        err_vec[LOG_BIT] |-> |err_vec[5:2]);

    // R8: the vector pulse lasts a single cycle.
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (err_vec != '0 || err_func != '0) |=> (err_vec == '0 && err_func == '0));

    // R7: without logging the pulse cycle follows acceptance at once.
    assert_nolog_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_log) |=> (state_q == ST_FIRE && !err_vec[LOG_BIT]));

    // R2: acceptance makes the block busy.
    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R5: completing the last write leads to the pulse cycle.
    assert_fire_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && wr_done) |=> err_vec[LOG_BIT]);

endmodule

// File: rtl/cerr_log_seq.sv
module cerr_log_seq
    import cerr_pkg::*;
#(
    parameter int FUNC_W    = 3,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NWR       = 4,
    parameter int BASE_ADDR = 'h81C,
    parameter int ADDR_STEP = 4,
    parameter int PEND_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CLASS_W-1:0]    req_class,
    input  logic [FUNC_W-1:0]     req_func,
    input  logic [NWR*DATA_W-1:0] req_hdr,
    input  logic                  req_log,
    output logic                  mgmt_wr_en,
    output logic [ADDR_W-1:0]     mgmt_addr,
    output logic [DATA_W-1:0]     mgmt_wdata,
    input  logic                  mgmt_ack,
    output logic [VEC_W-1:0]      err_vec,
    output logic [FUNC_W-1:0]     err_func,
    input  logic                  mreq_issue,
    input  logic                  mreq_done,
    output logic                  cpl_pending
);
    logic wr_start;
    logic wr_done;

    cerr_seq_ctrl #(.FUNC_W(FUNC_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_class (req_class),
        .req_func  (req_func),
        .req_log   (req_log),
        .wr_start  (wr_start),
        .wr_done   (wr_done),
        .err_vec   (err_vec),
        .err_func  (err_func)
    );

    cerr_hdr_writer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NWR       (NWR),
        .BASE_ADDR (BASE_ADDR),
        .ADDR_STEP (ADDR_STEP)
    ) u_writer (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_start),
        .hdr_in (req_hdr),
        .ack    (mgmt_ack),
        .wr_en  (mgmt_wr_en),
        .addr   (mgmt_addr),
        .data   (mgmt_wdata),
        .done   (wr_done)
    );

    cerr_pend_counter #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .issue   (mreq_issue),
        .retire  (mreq_done),
        .pending (cpl_pending)
    );

    // R2: while a sequence runs, no write happens with the block idle.
    assert_wr_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mgmt_wr_en |-> !req_ready);

    // R8: no pulse during a write phase.
    assert_no_vec_in_write_R8: assert property (@(posedge clk) disable iff (rst)
        mgmt_wr_en |-> err_vec == '0);

endmodule

// File: tb/cerr_log_seq_tb.sv
module cerr_log_seq_tb;
    localparam int PEND_W = 3;
    localparam int PMAX   = (1 << PEND_W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [5:0]   req_class;
    logic [2:0]   req_func;
    logic [127:0] req_hdr;
    logic         req_log;
    logic         mgmt_wr_en;
    logic [11:0]  mgmt_addr;
    logic [31:0]  mgmt_wdata;
    logic         mgmt_ack;
    logic [6:0]   err_vec;
    logic [2:0]   err_func;
    logic         mreq_issue;
    logic         mreq_done;
    logic         cpl_pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cerr_log_seq #(.PEND_W(PEND_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_class(req_class), .req_func(req_func), .req_hdr(req_hdr),
        .req_log(req_log), .mgmt_wr_en(mgmt_wr_en), .mgmt_addr(mgmt_addr),
        .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack), .err_vec(err_vec),
        .err_func(err_func), .mreq_issue(mreq_issue), .mreq_done(mreq_done),
        .cpl_pending(cpl_pending)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_vec(input logic [5:0] c, input logic lg);
        return {lg & (|c[5:2]), c};
    endfunction

    function automatic logic [31:0] exp_dw(input logic [127:0] h, input int i);
        return h[127-32*i -: 32];
    endfunction

    task automatic step();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_err(input logic [5:0] c, input logic [2:0] f,
                           input logic [127:0] h, input logic lg, input bit stray);
        bit eff;
        eff = lg && (|c[5:2]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_class = c; req_func = f; req_hdr = h; req_log = lg;
        step();
        // scramble request inputs; the block must use its captured copy
        req_class = ~c; req_func = ~f; req_hdr = ~h; req_log = ~lg;
        if (stray) req_valid = 1'b1;  // R2 offered while busy
        if (eff) begin
            for (int i = 0; i < 4; i++) begin
                int d;
                d = int'($urandom % 3);
                for (int j = 0; j < d; j++) begin
                    chk(mgmt_wr_en == 1'b1, "R4 strobe held", 64'(mgmt_wr_en), 64'd1);
                    chk(mgmt_addr == 12'(12'h81C + 4*i), "R3 address",
                        64'(mgmt_addr), 64'(12'h81C + 4*i));
                    chk(mgmt_wdata == exp_dw(h, i), "R4 data held",
                        64'(mgmt_wdata), 64'(exp_dw(h, i)));
                    chk(req_ready == 1'b0 && err_vec == 7'd0, "R2 busy during write",
                        64'({req_ready, err_vec}), 64'd0);
                    step();
                end
                chk(mgmt_wr_en == 1'b1, "R3 write strobe", 64'(mgmt_wr_en), 64'd1);
                chk(mgmt_addr == 12'(12'h81C + 4*i), "R3 address order",
                    64'(mgmt_addr), 64'(12'h81C + 4*i));
                chk(mgmt_wdata == exp_dw(h, i), "R3 header dword",
                    64'(mgmt_wdata), 64'(exp_dw(h, i)));
                mgmt_ack = 1'b1;
                step();
                mgmt_ack = 1'b0;
            end
            chk(err_vec == exp_vec(c, 1'b1), "R5 vector after last ack",
                64'(err_vec), 64'(exp_vec(c, 1'b1)));
        end else begin
            chk(err_vec == exp_vec(c, lg), lg ? "R6 vector without writes" : "R7 vector next cycle",
                64'(err_vec), 64'(exp_vec(c, lg)));
        end
        chk(err_func == f, "R5 function number", 64'(err_func), 64'(f));
        chk(mgmt_wr_en == 1'b0, eff ? "R3 writes finished" : "R6 R7 no write",
            64'(mgmt_wr_en), 64'd0);
        chk(req_ready == 1'b0, "R2 busy in pulse cycle", 64'(req_ready), 64'd0);
        step();
        chk(err_vec == 7'd0 && err_func == 3'd0, "R8 pulse one cycle",
            64'({err_vec, err_func}), 64'd0);
        chk(req_ready == 1'b1 && mgmt_wr_en == 1'b0, "R2 idle after pulse, stray ignored",
            64'({req_ready, mgmt_wr_en}), 64'h2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cnt;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; req_valid = 0; req_class = 0; req_func = 0; req_hdr = 0;
        req_log = 0; mgmt_ack = 0; mreq_issue = 0; mreq_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk({err_vec, err_func, mgmt_wr_en, cpl_pending} == '0, "R1 outputs zero",
            64'({err_vec, err_func, mgmt_wr_en, cpl_pending}), 64'd0);

        // directed corners
        run_err(6'b100000, 3'd5, 128'h00112233_44556677_8899AABB_CCDDEEFF, 1'b1, 1'b1);
        run_err(6'b000011, 3'd2, 128'hDEADBEEF_0BADF00D_CAFEF00D_12345678, 1'b1, 1'b0);
        run_err(6'b010100, 3'd7, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000, 1'b0, 1'b1);
        run_err(6'b000100, 3'd1, 128'h1, 1'b1, 1'b1);

        // random mix
        for (int k = 0; k < 30; k++) begin
            run_err(6'($urandom), 3'($urandom),
                    {$urandom, $urandom, $urandom, $urandom},
                    1'($urandom), 1'($urandom));
        end

        // R4: acknowledge without a pending write is ignored
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mgmt_ack = 1'b1;
            @(negedge clk);
            mgmt_ack = 1'b0;
            chk(mgmt_wr_en == 1'b0 && err_vec == 7'd0, "R4 stray ack ignored",
                64'({mgmt_wr_en, err_vec}), 64'd0);
        end

        // R9: saturate high, then drain to zero
        cnt = 0;
        for (int k = 0; k < PMAX + 3; k++) begin
            @(negedge clk);
            mreq_issue = 1'b1;
            @(negedge clk);
            mreq_issue = 1'b0;
            chk(cpl_pending == 1'b1, "R9 pending while issuing", 64'(cpl_pending), 64'd1);
        end
        for (int k = 0; k < PMAX; k++) begin
            chk(cpl_pending == 1'b1, "R9 pending before drain ends", 64'(cpl_pending), 64'd1);
            mreq_done = 1'b1;
            @(negedge clk);
        end
        mreq_done = 1'b0;
        chk(cpl_pending == 1'b0, "R9 ceiling saturation", 64'(cpl_pending), 64'd0);
        // extra completions at zero, then one issue
        mreq_done = 1'b1;
        repeat (3) @(negedge clk);
        mreq_done = 1'b0;
        mreq_issue = 1'b1;
        @(negedge clk);
        mreq_issue = 1'b0;
        chk(cpl_pending == 1'b1, "R9 floor saturation", 64'(cpl_pending), 64'd1);
        mreq_done = 1'b1;
        @(negedge clk);
        mreq_done = 1'b0;
        chk(cpl_pending == 1'b0, "R9 back to zero", 64'(cpl_pending), 64'd0);

        // R9: random issue/done against a model
        cnt = 0;
        for (int k = 0; k < 300; k++) begin
            logic iss, dn;
            iss = 1'($urandom); dn = 1'($urandom);
            mreq_issue = iss; mreq_done = dn;
            @(negedge clk);
            if (iss && !dn && cnt < PMAX) cnt++;
            else if (dn && !iss && cnt > 0) cnt--;
            chk(cpl_pending == (cnt != 0), "R9 random pending",
                64'(cpl_pending), 64'(cnt != 0));
        end
        mreq_issue = 0; mreq_done = 0;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule